// File: doc/BRIEF.md
# UART Task and Event Register File

This block is the software-facing control layer of a simple UART. A register bus writes or reads one 32-bit word per cycle. Software starts and stops the transmit and receive paths by writing 1 to trigger registers. It learns what happened from sticky event registers: transmit-ready, receive-ready, error and receive-timeout. A single level interrupt is raised when any event is set and its enable bit is on. The interrupt enable can be written whole, or bits can be set or cleared through two aliases.

The block is inert until a magic key is written to its enable register. Until then, writes are dropped and reads return zero. A separate serial shifter and receive FIFO connect through plain wires:
- The block drives the started flags and a one-cycle load strobe that carries the transmit byte.
- The shifter and FIFO return one-cycle pulses for byte sent, byte received and line break.

The block only stores the pin-select and baud words. It does not interpret them.

Top module: `uart_task_regs`

## Requirements
- R1: After reset, the four pin-select words read 0xFFFFFFFF and the baud word reads 0x04000000. The event words, the interrupt enable, the error source and the transmit data read 0. The started flags, the pending flag, the load strobe and irq are 0, and the block is disabled.
- R2: Only a write of 4 to the enable word (byte address 0x304) enables the block. Any other nonzero value leaves the enabled state unchanged.
- R3: While disabled, every write except one to the enable word is ignored, and every read returns 0.
- R4: Writing 0 to the enable word disables the block, clears both started flags and sets the receive-timeout event.
- R5: Writing exactly 1 to start-receive (0x000) or start-transmit (0x008) sets the matching started flag. Other values have no effect.
- R6: Writing 1 to stop-transmit (0x00C) clears only the transmit flag. Writing 1 to stop-receive (0x004) clears the receive flag and sets receive-timeout. Writing 1 to pause (0x010) clears both flags and sets receive-timeout.
- R7: The interrupt enable has four bits: bit 0 receive-ready, bit 1 transmit-ready, bit 2 error, bit 3 receive-timeout.
  - A write to 0x200 loads the enable.
  - A write to 0x204 ORs the written bits in.
  - A write to 0x208 clears the bits written as 1.
  - Reads of all three addresses return the enable.
- R8: irq is the OR over the four events of (event set AND its enable bit). It reflects a write or an event pulse in the cycle after the clock edge that takes it.
- R9: Each event word reads 1 or 0:
  - Receive-ready is at 0x100, transmit-ready at 0x104, error at 0x108 and receive-timeout at 0x10C.
  - A bus write stores whether the written value is nonzero.
  - A hardware pulse sets its event: rx_evt sets receive-ready, tx_done sets transmit-ready and brk_evt sets error.
  - A pulse wins over a bus write to the same event in the same cycle.
- R10: A write to transmit data (0x318) is accepted only while transmit is started and no byte is pending.
  - On acceptance, the pending flag sets and tx_load pulses for one cycle with tx_byte holding bits 7:0 of the write. Reading 0x318 returns that byte.
  - tx_done clears the pending flag.
- R11: The two-bit error source at 0x300 is write-one-to-clear. brk_evt sets both of its bits and the error event, and wins over a clear in the same cycle.
- R12: The pin-select words (0x308, 0x30C, 0x310, 0x314) and the baud word (0x31C) store and return any 32-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| tx_started | output | 1 | Transmit path started |
| rx_started | output | 1 | Receive path started |
| tx_load | output | 1 | One-cycle strobe for a new byte |
| tx_byte | output | 8 | Byte to send |
| tx_pending | output | 1 | A byte awaits completion |
| tx_done | input | 1 | Pulse: byte sent |
| rx_evt | input | 1 | Pulse: byte received |
| brk_evt | input | 1 | Pulse: line break seen |
| irq | output | 1 | Level interrupt |

## Verification
Two collisions can occur in the same cycle:
- a bus write that clears an event and the hardware pulse that sets it;
- a write-one-to-clear of the error source and a line break.

The bench provokes each one by raising the pulse for exactly the clock edge that takes the bus write. It then reads the word back and expects the set to have won. The interrupt function is swept over all 256 pairs of event pattern and enable mask, and irq is compared with an OR of ANDs computed in the bench.

// File: rtl/uart_task_regs.sv
module uart_task_regs #(
  parameter int          AW         = 12,
  parameter logic [31:0] BAUD_INIT  = 32'h0400_0000,
  parameter logic [31:0] ENABLE_KEY = 32'd4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          tx_started,
  output logic          rx_started,
  output logic          tx_load,
  output logic [7:0]    tx_byte,
  output logic          tx_pending,
  input  logic          tx_done,
  input  logic          rx_evt,
  input  logic          brk_evt,
  output logic          irq
);

  localparam logic [AW-1:0] A_RXGO   = AW'('h000);
  localparam logic [AW-1:0] A_RXHALT = AW'('h004);
  localparam logic [AW-1:0] A_TXGO   = AW'('h008);
  localparam logic [AW-1:0] A_TXHALT = AW'('h00C);
  localparam logic [AW-1:0] A_PAUSE  = AW'('h010);
  localparam logic [AW-1:0] A_EVRXR  = AW'('h100);
  localparam logic [AW-1:0] A_EVTXR  = AW'('h104);
  localparam logic [AW-1:0] A_EVERR  = AW'('h108);
  localparam logic [AW-1:0] A_EVRXTO = AW'('h10C);
  localparam logic [AW-1:0] A_IEN    = AW'('h200);
  localparam logic [AW-1:0] A_IESET  = AW'('h204);
  localparam logic [AW-1:0] A_IECLR  = AW'('h208);
  localparam logic [AW-1:0] A_ERRSRC = AW'('h300);
  localparam logic [AW-1:0] A_ENABLE = AW'('h304);
  localparam logic [AW-1:0] A_PIN0   = AW'('h308);
  localparam logic [AW-1:0] A_PIN1   = AW'('h30C);
  localparam logic [AW-1:0] A_PIN2   = AW'('h310);
  localparam logic [AW-1:0] A_PIN3   = AW'('h314);
  localparam logic [AW-1:0] A_TXDATA = AW'('h318);
  localparam logic [AW-1:0] A_BAUD   = AW'('h31C);
  localparam int            NPIN     = 4;

  logic        enabled;
  logic        ev_rxrdy, ev_txrdy, ev_err, ev_rxto;
  logic [3:0]  ien;
  logic [1:0]  errsrc;
  logic [31:0] pin_sel [NPIN];
  logic [31:0] baud;

  logic we, one, nz;
  logic dis_wr, stop_rx, stop_tx, tx_accept;

  assign we  = bus_sel && bus_wr && (enabled || bus_addr == A_ENABLE);
  assign one = bus_wdata == 32'd1;
  assign nz  = |bus_wdata;

  assign dis_wr    = we && bus_addr == A_ENABLE && !nz;
  assign stop_rx   = dis_wr || (we && one && (bus_addr == A_RXHALT || bus_addr == A_PAUSE));
  assign stop_tx   = dis_wr || (we && one && (bus_addr == A_TXHALT || bus_addr == A_PAUSE));
  assign tx_accept = we && bus_addr == A_TXDATA && tx_started && !tx_pending;

  assign irq = (ev_rxrdy && ien[0]) || (ev_txrdy && ien[1]) ||
               (ev_err && ien[2]) || (ev_rxto && ien[3]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= 1'b0;
    end else if (we && bus_addr == A_ENABLE) begin
      if (!nz)                          enabled <= 1'b0;
      else if (bus_wdata == ENABLE_KEY) enabled <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_started <= 1'b0;
      tx_started <= 1'b0;
    end else begin
      if (stop_rx)                              rx_started <= 1'b0;
      else if (we && one && bus_addr == A_RXGO) rx_started <= 1'b1;
      if (stop_tx)                              tx_started <= 1'b0;
      else if (we && one && bus_addr == A_TXGO) tx_started <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_rxrdy <= 1'b0;
      ev_txrdy <= 1'b0;
      ev_err   <= 1'b0;
      ev_rxto  <= 1'b0;
    end else begin
      if (rx_evt)                      ev_rxrdy <= 1'b1;
      else if (we && bus_addr == A_EVRXR)  ev_rxrdy <= nz;
      if (tx_done)                     ev_txrdy <= 1'b1;
      else if (we && bus_addr == A_EVTXR)  ev_txrdy <= nz;
      if (brk_evt)                     ev_err <= 1'b1;
      else if (we && bus_addr == A_EVERR)  ev_err <= nz;
      if (stop_rx)                     ev_rxto <= 1'b1;
      else if (we && bus_addr == A_EVRXTO) ev_rxto <= nz;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien    <= '0;
      errsrc <= '0;
    end else begin
      if (we && bus_addr == A_IEN)        ien <= bus_wdata[3:0];
      else if (we && bus_addr == A_IESET) ien <= ien | bus_wdata[3:0];
      else if (we && bus_addr == A_IECLR) ien <= ien & ~bus_wdata[3:0];
      if (brk_evt)                         errsrc <= 2'b11;
      else if (we && bus_addr == A_ERRSRC) errsrc <= errsrc & ~bus_wdata[1:0];
    end
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pin_sel[p] <= '1;
      else if (we && bus_addr == A_PIN0 + AW'(4 * p))
        pin_sel[p] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        baud <= BAUD_INIT;
    else if (we && bus_addr == A_BAUD) baud <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pending <= 1'b0;
      tx_load    <= 1'b0;
      tx_byte    <= '0;
    end else begin
      tx_load <= tx_accept;
      if (tx_accept) begin
        tx_byte    <= bus_wdata[7:0];
        tx_pending <= 1'b1;
      end else if (tx_done) begin
        tx_pending <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (enabled) begin
      case (bus_addr)
        A_EVRXR:                   bus_rdata = {31'd0, ev_rxrdy};
        A_EVTXR:                   bus_rdata = {31'd0, ev_txrdy};
        A_EVERR:                   bus_rdata = {31'd0, ev_err};
        A_EVRXTO:                  bus_rdata = {31'd0, ev_rxto};
        A_IEN, A_IESET, A_IECLR:   bus_rdata = {28'd0, ien};
        A_ERRSRC:                  bus_rdata = {30'd0, errsrc};
        A_ENABLE:                  bus_rdata = ENABLE_KEY;
        A_PIN0:                    bus_rdata = pin_sel[0];
        A_PIN1:                    bus_rdata = pin_sel[1];
        A_PIN2:                    bus_rdata = pin_sel[2];
        A_PIN3:                    bus_rdata = pin_sel[3];
        A_TXDATA:                  bus_rdata = {24'd0, tx_byte};
        A_BAUD:                    bus_rdata = baud;
        default:                   bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/uart_task_regs_chk.sv
module uart_task_regs_chk #(
  parameter int          AW         = 12,
  parameter logic [31:0] ENABLE_KEY = 32'd4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic          tx_started,
  input logic          rx_started,
  input logic          tx_load,
  input logic          tx_pending,
  input logic          rx_evt,
  input logic          brk_evt,
  input logic          irq,
  input logic          enabled,
  input logic          ev_rxto,
  input logic          ev_err,
  input logic [1:0]    errsrc,
  input logic [3:0]    ien
);
  localparam logic [AW-1:0] C_ENABLE = AW'('h304);

  AST_DISABLED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !enabled) |-> bus_rdata == 32'd0); // R3

  AST_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == C_ENABLE && bus_wdata == 32'd0)
      |=> (!tx_started && !rx_started && ev_rxto && !enabled)); // R4

  AST_KEY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enabled) |-> $past(bus_sel && bus_wr && bus_addr == C_ENABLE &&
                             bus_wdata == ENABLE_KEY)); // R2

  AST_LOAD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> (tx_pending && !$past(tx_pending) && $past(tx_started))); // R10

  AST_BREAK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> (ev_err && errsrc == 2'b11)); // R11

  AST_IRQ_ON_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt && ien[0]) |=> irq); // R8
endmodule

bind uart_task_regs uart_task_regs_chk #(.AW(AW), .ENABLE_KEY(ENABLE_KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .tx_started(tx_started), .rx_started(rx_started), .tx_load(tx_load),
  .tx_pending(tx_pending), .rx_evt(rx_evt), .brk_evt(brk_evt), .irq(irq),
  .enabled(enabled), .ev_rxto(ev_rxto), .ev_err(ev_err), .errsrc(errsrc),
  .ien(ien)
);

// File: tb/uart_task_regs_test.sv
`timescale 1ns/1ps
module uart_task_regs_test;
  localparam int AW = 12;
  localparam logic [AW-1:0] RXGO = 'h000, RXHALT = 'h004, TXGO = 'h008,
    TXHALT = 'h00C, PAUSE = 'h010, EVRXR = 'h100, EVTXR = 'h104, EVERR = 'h108,
    EVRXTO = 'h10C, IEN = 'h200, IESET = 'h204, IECLR = 'h208, ERRSRC = 'h300,
    ENA = 'h304, PIN0 = 'h308, TXDATA = 'h318, BAUD = 'h31C;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tx_started, rx_started, tx_load, tx_pending, irq;
  logic [7:0] tx_byte;
  logic tx_done = 0, rx_evt = 0, brk_evt = 0;
  int nvec = 0, nbad = 0;
  logic [31:0] r;

  always #10 clk = ~clk;

  uart_task_regs #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_started(tx_started), .rx_started(rx_started), .tx_load(tx_load),
    .tx_byte(tx_byte), .tx_pending(tx_pending), .tx_done(tx_done),
    .rx_evt(rx_evt), .brk_evt(brk_evt), .irq(irq));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic expect_rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(v == e, tag, v, e);
  endtask

  task automatic done;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    done();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 flags and outputs at reset, R3 reads zero while disabled
    chk({irq, tx_started, rx_started, tx_pending, tx_load} == 0, "R1 outputs", {irq, tx_started, rx_started, tx_pending, tx_load}, 0);
    expect_rd(PIN0, 0, "R3 read disabled");
    // R2 sweep of non-key values
    for (int v = 1; v < 16; v++) if (v != 4) begin
      wr(ENA, v);
      expect_rd(PIN0, 0, "R2 non-key");
    end
    wr(ENA, 32'h104);
    expect_rd(PIN0, 0, "R2 non-key wide");
    wr(ENA, 4);
    // R1 reset values
    for (int p = 0; p < 4; p++) expect_rd(PIN0 + AW'(4 * p), 32'hFFFF_FFFF, "R1 pin");
    expect_rd(BAUD, 32'h0400_0000, "R1 baud");
    expect_rd(EVRXR, 0, "R1 ev"); expect_rd(EVTXR, 0, "R1 ev");
    expect_rd(EVERR, 0, "R1 ev"); expect_rd(EVRXTO, 0, "R1 ev");
    expect_rd(IEN, 0, "R1 ien"); expect_rd(ERRSRC, 0, "R1 errsrc");
    expect_rd(TXDATA, 0, "R1 txdata");
    expect_rd(ENA, 4, "R2 enabled");
    // R3 writes ignored while disabled
    wr(ENA, 0);
    wr(PIN0, 32'h1234); wr(IEN, 4'hF); wr(RXGO, 1); wr(TXGO, 1); wr(EVRXR, 1);
    chk({tx_started, rx_started, irq} == 0, "R3 flags", {tx_started, rx_started, irq}, 0);
    expect_rd(IEN, 0, "R3 read disabled");
    wr(ENA, 4);
    expect_rd(PIN0, 32'hFFFF_FFFF, "R3 pin untouched");
    expect_rd(IEN, 0, "R3 ien untouched");
    expect_rd(EVRXR, 0, "R3 ev untouched");
    wr(EVRXTO, 0);
    // R5 start triggers
    wr(RXGO, 2); wr(TXGO, 3);
    chk({tx_started, rx_started} == 0, "R5 non-one", {tx_started, rx_started}, 0);
    wr(RXGO, 1);
    chk({tx_started, rx_started} == 2'b01, "R5 rx", {tx_started, rx_started}, 2'b01);
    wr(TXGO, 1);
    chk({tx_started, rx_started} == 2'b11, "R5 tx", {tx_started, rx_started}, 2'b11);
    // R6 stops
    wr(TXHALT, 2); wr(RXHALT, 2); wr(PAUSE, 2);
    chk({tx_started, rx_started} == 2'b11, "R6 non-one", {tx_started, rx_started}, 2'b11);
    wr(TXHALT, 1);
    chk({tx_started, rx_started} == 2'b01, "R6 txhalt", {tx_started, rx_started}, 2'b01);
    expect_rd(EVRXTO, 0, "R6 txhalt no rxto");
    wr(TXGO, 1); wr(RXHALT, 1);
    chk({tx_started, rx_started} == 2'b10, "R6 rxhalt", {tx_started, rx_started}, 2'b10);
    expect_rd(EVRXTO, 1, "R6 rxhalt rxto");
    wr(EVRXTO, 0); wr(RXGO, 1); wr(PAUSE, 1);
    chk({tx_started, rx_started} == 0, "R6 pause", {tx_started, rx_started}, 0);
    expect_rd(EVRXTO, 1, "R6 pause rxto");
    // R4 disable
    wr(EVRXTO, 0); wr(RXGO, 1); wr(TXGO, 1); wr(ENA, 0);
    chk({tx_started, rx_started} == 0, "R4 flags", {tx_started, rx_started}, 0);
    wr(ENA, 4);
    expect_rd(EVRXTO, 1, "R4 rxto");
    wr(EVRXTO, 0);
    // R7 enable aliases, sweep
    for (int v = 0; v < 16; v++) for (int s = 0; s < 16; s += 5) begin
      wr(IEN, v);
      expect_rd(IESET, v, "R7 alias read");
      wr(IESET, s);
      expect_rd(IEN, v | s, "R7 set");
      wr(IECLR, s);
      expect_rd(IECLR, (v | s) & ~s, "R7 clr");
    end
    // R8 irq sweep
    for (int e = 0; e < 16; e++) for (int m = 0; m < 16; m++) begin
      wr(EVRXR, e & 1); wr(EVTXR, (e >> 1) & 1); wr(EVERR, (e >> 2) & 1); wr(EVRXTO, (e >> 3) & 1);
      wr(IEN, m);
      chk(irq == ((e & m) != 0), "R8 irq", irq, (e & m) != 0);
    end
    // R9 pulses and collisions
    wr(IEN, 0); wr(EVRXR, 0); wr(EVTXR, 0); wr(EVERR, 0); wr(EVRXTO, 0);
    rx_evt = 1; wr(EVRXR, 0); rx_evt = 0;
    expect_rd(EVRXR, 1, "R9 rx pulse wins");
    tx_done = 1; @(negedge clk); tx_done = 0;
    expect_rd(EVTXR, 1, "R9 tx pulse");
    wr(EVRXR, 0); wr(IEN, 1);
    rx_evt = 1; @(negedge clk); rx_evt = 0;
    chk(irq == 1, "R8 irq after pulse", irq, 1);
    wr(IEN, 0); wr(EVTXR, 0);
    // R10 transmit data
    wr(TXHALT, 1); wr(TXDATA, 32'h5A);
    chk({tx_load, tx_pending} == 0, "R10 not started", {tx_load, tx_pending}, 0);
    wr(TXGO, 1); wr(TXDATA, 32'h1A5);
    chk({tx_load, tx_pending} == 2'b11 && tx_byte == 8'hA5, "R10 accept", {tx_load, tx_pending, tx_byte}, {2'b11, 8'hA5});
    wr(TXDATA, 32'h3C);
    chk(tx_load == 0, "R10 load one cycle", tx_load, 0);
    expect_rd(TXDATA, 32'hA5, "R10 pending reject");
    tx_done = 1; @(negedge clk); tx_done = 0;
    chk(tx_pending == 0, "R10 done", tx_pending, 0);
    expect_rd(EVTXR, 1, "R10 txrdy");
    wr(TXDATA, 32'h3C);
    expect_rd(TXDATA, 32'h3C, "R10 second byte");
    tx_done = 1; @(negedge clk); tx_done = 0;
    // R11 error source
    brk_evt = 1; @(negedge clk); brk_evt = 0;
    expect_rd(ERRSRC, 3, "R11 break bits");
    expect_rd(EVERR, 1, "R11 error event");
    wr(ERRSRC, 1);
    expect_rd(ERRSRC, 2, "R11 w1c bit0");
    wr(ERRSRC, 2);
    expect_rd(ERRSRC, 0, "R11 w1c bit1");
    brk_evt = 1; wr(ERRSRC, 3); brk_evt = 0;
    expect_rd(ERRSRC, 3, "R11 break wins");
    // R12 config store
    for (int k = 0; k < 8; k++) begin
      logic [31:0] pat;
      pat = 32'h9E37_79B9 * (k + 1);
      for (int p = 0; p < 4; p++) wr(PIN0 + AW'(4 * p), pat ^ p);
      wr(BAUD, ~pat);
      for (int p = 0; p < 4; p++) expect_rd(PIN0 + AW'(4 * p), pat ^ p, "R12 pin");
      expect_rd(BAUD, ~pat, "R12 baud");
    end
    done();
  end
endmodule